// File: doc/BRIEF.md
# SD Command/Response Engine

This block is the command-line half of an SD/MMC host. Software loads a 6-bit command index and a 32-bit argument into registers, then writes the control register with a transfer-type code and the launch bit set. The engine sends a 48-bit command frame on the CMD line, protected by a CRC7 that it computes itself. It then waits a bounded time for the card's reply and deserialises either a 48-bit short reply or a 136-bit long reply into five response words. For commands that leave the card busy, it also waits for DAT0 to return high.

When the transaction ends, the engine clears the launch bit. Errors are reported as two sticky flags in a state register: a missing reply and a reply whose CRC7 does not match. The engine runs on the card clock (one `clk` cycle per card clock). Register reads are combinational on a word index.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset the control, index, argument and enable registers and all response words read zero. Register word indices are: enable 0, control 1, state 2, index 3, argument 4, response words 0..4 at indices 5..9. The enable, index and argument registers read back what was written.
- R2: A launch with type code 1, 2 or 3 drives `cmd_oe` for exactly 48 cycles. The frame is sent most significant bit first and reads {0, 1, index[5:0], argument[31:0], CRC7, 1}. The CRC7 uses the polynomial x^7+x^3+1 over the first 40 bits.
- R3: For type 1 or 3, the 48 received bits occupy the low 48 bits of the response store. Response word 0 holds card status [23:0] in bits [31:8] and {CRC7, end bit} in bits [7:0]. Response word 1 reads {16'h0, 2'b00, index echo[5:0], status[31:24]}.
- R4: For type code 2, response words 0..3 hold the last 128 received bits, with word 0 least significant. Response word 4 holds the 8 header bits in bits [7:0].
- R5: A reply whose received CRC7 differs from the CRC7 of its covered bits sets state bit 0. Short replies cover bits 47..8; long replies cover the 120 bits after the header. A matching reply leaves state bit 0 clear.
- R6: A reply start bit sampled within 64 cycles after the command end bit is accepted. If none arrives, state bit 4 (no response) is set.
- R7: Control bit 7 (launch) stays set for the whole transaction and is cleared by the engine when it ends.
- R8: Control bits [23:16] and the type code are unchanged when the engine clears the launch bit.
- R9: With type code 3, the launch bit stays set while DAT0 is low after the reply, and clears once DAT0 reads high. If DAT0 stays low for BUSY_LIMIT cycles, state bit 4 is set.
- R10: Type codes other than 1, 2 and 3 (including 4 and 5) drive nothing on CMD, set state bit 4 and clear the launch bit.
- R11: A new launch clears state bits 0 and 4.
- R12: State bit 7 reads the live DAT0 level.
- R13: While the launch bit is set, writes to the control, index and argument registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmd_in | input | 1 | CMD line level from the card |
| cmd_out | output | 1 | CMD line level driven to the card |
| cmd_oe | output | 1 | CMD line output enable |
| dat0_in | input | 1 | DAT0 line level |

## Verification
The checker watches several rules on every cycle:
- CMD is driven only while a launch is pending, and only for the three supported type codes.
- The launch bit drops right after the sequencer finishes, and the delay field stays intact when it drops.
- Index and argument are frozen while busy.
- The error flags are clear once a supported command starts.

Frame bit order and CRC, the packing of short and long replies, the 64-cycle reply window boundary, the CRC-mismatch flag, and the busy wait with its expiry are shown only by the bench's scenarios. There, a card model checks each frame against a queued expectation and answers with crafted replies.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  // register word indices
  localparam logic [3:0] IX_EN    = 4'd0;
  localparam logic [3:0] IX_CTRL  = 4'd1;
  localparam logic [3:0] IX_STATE = 4'd2;
  localparam logic [3:0] IX_IDX   = 4'd3;
  localparam logic [3:0] IX_ARG   = 4'd4;
  localparam logic [3:0] IX_RSP0  = 4'd5;
  localparam int         RSP_WORDS = 5;

  localparam int LAUNCH_BIT = 7;

  // transfer type codes
  localparam logic [3:0] TY_SHORT = 4'd1;
  localparam logic [3:0] TY_LONG  = 4'd2;
  localparam logic [3:0] TY_BUSY  = 4'd3;

  // frame geometry
  localparam int BODY_BITS  = 40;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int LONG_HDR   = 8;
  localparam int LONG_CRC_END = 128;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SEND, SQ_WAIT, SQ_RECV, SQ_BUSY, SQ_DONE
  } sq_state_t;

  function automatic logic ty_ok(input logic [3:0] ty);
    return (ty == TY_SHORT) || (ty == TY_LONG) || (ty == TY_BUSY);
  endfunction
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  input  logic       shift,
  output logic [6:0] crc
);
  logic [6:0] crc_d;
  logic       fb;

  always_comb begin
    fb    = din ^ crc[6];
    crc_d = crc;
    if (clr)        crc_d = '0;
    else if (en)    crc_d = {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    else if (shift) crc_d = {crc[5:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= '0;
    else        crc <= crc_d;
  end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq import sdcmd_pkg::*; #(
  parameter int RESP_WAIT  = 64,
  parameter int BUSY_LIMIT = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [3:0]           mode,
  input  logic [5:0]           idx,
  input  logic [31:0]          arg,
  input  logic                 cmd_in,
  input  logic                 dat0_in,
  output logic                 cmd_out,
  output logic                 cmd_oe,
  output logic                 done,
  output logic                 noresp,
  output logic                 crcerr,
  output logic [LONG_BITS-1:0] rsp
);
  localparam int TW = $clog2(RESP_WAIT + 1);
  localparam int BW = $clog2(BUSY_LIMIT + 1);
  localparam logic [7:0] C_BODY  = 8'(BODY_BITS);
  localparam logic [7:0] C_SLAST = 8'(SHORT_BITS - 1);
  localparam logic [7:0] C_LLAST = 8'(LONG_BITS - 1);
  localparam logic [7:0] C_HDR   = 8'(LONG_HDR);
  localparam logic [7:0] C_LCRC  = 8'(LONG_CRC_END);
  localparam logic [TW-1:0] T_LAST = TW'(RESP_WAIT - 1);
  localparam logic [BW-1:0] B_LAST = BW'(BUSY_LIMIT - 1);

  sq_state_t st_q, st_d;
  logic [7:0]           cnt_q, cnt_d;
  logic [TW-1:0]        tcnt_q, tcnt_d;
  logic [BW-1:0]        bcnt_q, bcnt_d;
  logic [BODY_BITS-1:0] tx_q, tx_d;
  logic [LONG_BITS-1:0] rx_q, rx_d;
  logic                 long_q, long_d, bw_q, bw_d;
  logic                 nr_q, nr_d, ce_q, ce_d;
  logic                 crc_clr, tx_en, tx_sh, rx_en;
  logic [6:0]           tx_crc, rx_crc;

  sdcmd_crc7 u_txcrc (.clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(tx_en),
                      .din(tx_q[BODY_BITS-1]), .shift(tx_sh), .crc(tx_crc));
  sdcmd_crc7 u_rxcrc (.clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(rx_en),
                      .din(cmd_in), .shift(1'b0), .crc(rx_crc));

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; tcnt_d = tcnt_q; bcnt_d = bcnt_q;
    tx_d = tx_q; rx_d = rx_q; long_d = long_q; bw_d = bw_q;
    nr_d = nr_q; ce_d = ce_q;
    crc_clr = 1'b0; tx_en = 1'b0; tx_sh = 1'b0; rx_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (go) begin
        crc_clr = 1'b1; nr_d = 1'b0; ce_d = 1'b0; rx_d = '0; cnt_d = '0;
        if (ty_ok(mode)) begin
          st_d   = SQ_SEND;
          tx_d   = {2'b01, idx, arg};
          long_d = (mode == TY_LONG);
          bw_d   = (mode == TY_BUSY);
        end else begin
          st_d = SQ_DONE;
          nr_d = 1'b1;
        end
      end
      SQ_SEND: begin
        if (cnt_q < C_BODY) begin
          tx_en = 1'b1;
          tx_d  = {tx_q[BODY_BITS-2:0], 1'b0};
        end else begin
          tx_sh = 1'b1;
        end
        if (cnt_q == C_SLAST) begin
          st_d = SQ_WAIT; tcnt_d = '0;
        end else begin
          cnt_d = cnt_q + 8'd1;
        end
      end
      SQ_WAIT: begin
        if (!cmd_in) begin
          st_d = SQ_RECV; cnt_d = 8'd1;
          rx_d = {rx_q[LONG_BITS-2:0], 1'b0};
        end else if (tcnt_q == T_LAST) begin
          st_d = SQ_DONE; nr_d = 1'b1;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      SQ_RECV: begin
        rx_d  = {rx_q[LONG_BITS-2:0], cmd_in};
        rx_en = long_q ? (cnt_q >= C_HDR && cnt_q < C_LCRC) : (cnt_q < C_BODY);
        if (cnt_q == (long_q ? C_LLAST : C_SLAST)) begin
          ce_d   = (rx_crc != rx_q[6:0]);
          st_d   = bw_q ? SQ_BUSY : SQ_DONE;
          bcnt_d = '0;
        end else begin
          cnt_d = cnt_q + 8'd1;
        end
      end
      SQ_BUSY: begin
        if (dat0_in) st_d = SQ_DONE;
        else if (bcnt_q == B_LAST) begin
          st_d = SQ_DONE; nr_d = 1'b1;
        end else bcnt_d = bcnt_q + 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; cnt_q <= '0; tcnt_q <= '0; bcnt_q <= '0;
      tx_q <= '0; rx_q <= '0; long_q <= 1'b0; bw_q <= 1'b0;
      nr_q <= 1'b0; ce_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; tcnt_q <= tcnt_d; bcnt_q <= bcnt_d;
      tx_q <= tx_d; rx_q <= rx_d; long_q <= long_d; bw_q <= bw_d;
      nr_q <= nr_d; ce_q <= ce_d;
    end
  end

  always_comb begin
    cmd_oe  = (st_q == SQ_SEND);
    cmd_out = 1'b1;
    if (cmd_oe) begin
      if (cnt_q < C_BODY)       cmd_out = tx_q[BODY_BITS-1];
      else if (cnt_q < C_SLAST) cmd_out = tx_crc[6];
    end
  end

  assign done   = (st_q == SQ_DONE);
  assign noresp = nr_q;
  assign crcerr = ce_q;
  assign rsp    = rx_q;
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine import sdcmd_pkg::*; #(
  parameter int RESP_WAIT  = 64,
  parameter int BUSY_LIMIT = 1024,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              dat0_in
);
  logic [1:0]  rs_q;
  logic        rst_i;
  logic [31:0] en_q, ctrl_q, ctrl_d, arg_q;
  logic [5:0]  idx_q;
  logic        busy, go, wr_en, wr_ctrl, wr_idx, wr_arg, ctrl_ce;
  logic        seq_done, flag_noresp, flag_crcerr;
  logic [LONG_BITS-1:0] rsp;
  logic [31:0] rsp_w [RSP_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_comb begin
    busy    = ctrl_q[LAUNCH_BIT];
    wr_en   = reg_we && (reg_addr == ADDR_W'(IX_EN));
    wr_ctrl = reg_we && (reg_addr == ADDR_W'(IX_CTRL)) && !busy;
    wr_idx  = reg_we && (reg_addr == ADDR_W'(IX_IDX))  && !busy;
    wr_arg  = reg_we && (reg_addr == ADDR_W'(IX_ARG))  && !busy;
    go      = wr_ctrl && reg_wdata[LAUNCH_BIT];
    ctrl_ce = wr_ctrl || seq_done;
    ctrl_d  = ctrl_q;
    if (wr_ctrl)       ctrl_d = reg_wdata;
    else if (seq_done) ctrl_d[LAUNCH_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q <= '0; ctrl_q <= '0; idx_q <= '0; arg_q <= '0;
    end else begin
      if (wr_en)   en_q   <= reg_wdata;
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (wr_idx)  idx_q  <= reg_wdata[5:0];
      if (wr_arg)  arg_q  <= reg_wdata;
    end
  end

  sdcmd_seq #(.RESP_WAIT(RESP_WAIT), .BUSY_LIMIT(BUSY_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_i), .go(go), .mode(reg_wdata[3:0]),
    .idx(idx_q), .arg(arg_q), .cmd_in(cmd_in), .dat0_in(dat0_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .done(seq_done),
    .noresp(flag_noresp), .crcerr(flag_crcerr), .rsp(rsp)
  );

  for (genvar k = 0; k < RSP_WORDS; k++) begin : g_rsp
    if (32*k + 32 <= LONG_BITS) begin : g_full
      assign rsp_w[k] = rsp[32*k +: 32];
    end else begin : g_part
      assign rsp_w[k] = {{(32*k + 32 - LONG_BITS){1'b0}}, rsp[LONG_BITS-1:32*k]};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(IX_EN):    reg_rdata = en_q;
      ADDR_W'(IX_CTRL):  reg_rdata = ctrl_q;
      ADDR_W'(IX_STATE): reg_rdata = {24'h0, dat0_in, 2'b00, flag_noresp, 3'b000, flag_crcerr};
      ADDR_W'(IX_IDX):   reg_rdata = {26'h0, idx_q};
      ADDR_W'(IX_ARG):   reg_rdata = arg_q;
      default: begin
        for (int k = 0; k < RSP_WORDS; k++)
          if (reg_addr == ADDR_W'(IX_RSP0) + ADDR_W'(k)) reg_rdata = rsp_w[k];
      end
    endcase
  end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_oe,
  input logic [31:0] ctrl_q,
  input logic [31:0] arg_q,
  input logic [5:0]  idx_q,
  input logic        seq_done,
  input logic        flag_noresp,
  input logic        flag_crcerr
);
  // R2: CMD is driven only while a launch is pending
  assert_drive_when_launched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> ctrl_q[7]);
  // R10: unsupported type codes never drive CMD
  assert_no_drive_bad_type_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> (ctrl_q[3:0] == 4'd1 || ctrl_q[3:0] == 4'd2 || ctrl_q[3:0] == 4'd3));
  // R7: launch bit drops right after the sequencer finishes
  assert_launch_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !ctrl_q[7]);
  // R8: delay field survives the self-clear
  assert_delay_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[7]) |-> $stable(ctrl_q[23:16]));
  // R11: error flags are clear once a supported command starts
  assert_flags_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_q[7]) && cmd_oe) |-> (!flag_noresp && !flag_crcerr));
  // R13: index and argument frozen while busy
  assert_frozen_when_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] |=> ($stable(arg_q) && $stable(idx_q)));
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_oe(cmd_oe), .ctrl_q(ctrl_q), .arg_q(arg_q),
  .idx_q(idx_q), .seq_done(seq_done), .flag_noresp(flag_noresp),
  .flag_crcerr(flag_crcerr)
);

// File: tb/sdcmd_engine_test.sv
module sdcmd_engine_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe;
  logic        dat0 = 1'b1;

  int checks = 0, errors = 0, frames_seen = 0;
  bit finished = 0;

  typedef struct {
    logic [47:0]  frame;
    int           delay;
    int           kind;
    logic [135:0] resp;
    int           busy_len;
  } exp_t;
  exp_t exp_q[$];

  sdcmd_engine uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .dat0_in(dat0));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [6:0] crc7f(input logic [127:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb;
      fb = v[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  // driver: queue the expectation, then launch
  task automatic launch(input logic [3:0] mode, input logic [5:0] idx, input logic [31:0] arg,
                        input int kind, input logic [31:0] status, input logic [119:0] data,
                        input int delay, input bit bad, input int busy_len, input logic [7:0] dly);
    exp_t e;
    logic [39:0] body;
    logic [6:0]  c;
    body = {2'b01, idx, arg};
    e.frame = {body, crc7f({88'h0, body}, 40), 1'b1};
    e.delay = delay; e.kind = kind; e.busy_len = busy_len; e.resp = '0;
    if (kind == 1) begin
      c = crc7f({88'h0, 2'b00, idx, status}, 40) ^ {6'h0, bad};
      e.resp = {88'h0, 2'b00, idx, status, c, 1'b1};
    end else if (kind == 2) begin
      c = crc7f({8'h0, data}, 120) ^ {6'h0, bad};
      e.resp = {2'b00, 6'h3f, data, c, 1'b1};
    end
    wr(4'd3, {26'h0, idx});
    wr(4'd4, arg);
    if (mode >= 4'd1 && mode <= 4'd3) exp_q.push_back(e);
    wr(4'd1, {8'h00, dly, 8'h00, 4'h8, mode});
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] d;
    int n = 0;
    do begin rd(4'd1, d); n++; end while (d[7] && n < 3000);
    chk(req, "launch bit cleared", {31'h0, d[7]}, 32'h0);
  endtask

  task automatic settle;
    repeat (220) @(negedge clk);
  endtask

  // monitor / card model: checks each frame against the queue and answers
  initial begin
    logic [47:0] frm = '0;
    int nb = 0;
    forever begin
      @(negedge clk);
      if (cmd_oe) begin
        frm = {frm[46:0], cmd_out}; nb++;
      end else if (nb > 0) begin
        exp_t e;
        frames_seen++;
        chk("R2", "frame length", nb, 48);
        nb = 0;
        if (exp_q.size() == 0) begin
          chk("R2", "unexpected frame", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk("R2", "frame bits 47:16", frm[47:16], e.frame[47:16]);
          chk("R2", "frame bits 15:0", {16'h0, frm[15:0]}, {16'h0, e.frame[15:0]});
          if (e.kind != 0) begin
            repeat (e.delay) @(negedge clk);
            for (int i = (e.kind == 2 ? 135 : 47); i >= 0; i--) begin
              cmd_in = e.resp[i];
              if (i == 0 && e.busy_len > 0) dat0 = 1'b0;
              @(negedge clk);
            end
            cmd_in = 1'b1;
            if (e.busy_len > 0) begin
              repeat (e.busy_len) @(negedge clk);
              dat0 = 1'b1;
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [119:0] ldat;
    int fs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state and readback
    rd(4'd1, d); chk("R1", "ctrl after reset", d, 32'h0);
    rd(4'd2, d); chk("R1", "state after reset", d, 32'h80);
    rd(4'd5, d); chk("R1", "rsp0 after reset", d, 32'h0);
    chk("R1", "cmd_oe after reset", {31'h0, cmd_oe}, 32'h0);
    wr(4'd0, 32'h0000_0005); rd(4'd0, d); chk("R1", "enable readback", d, 32'h5);

    // R2 R3 R7 R8 short command
    launch(4'd1, 6'd17, 32'h1234_5678, 1, 32'hA5C3_0F1E, '0, 5, 0, 0, 8'hAB);
    wait_idle("R7");
    rd(4'd1, d); chk("R8", "ctrl delay kept", d, 32'h00AB_0001);
    rd(4'd2, d); chk("R5", "no crc error", d, 32'h80);
    rd(4'd5, d); chk("R3", "rsp0", d[31:8], 32'h00C3_0F1E);
    rd(4'd6, d); chk("R3", "rsp1", d, {16'h0, 2'b00, 6'd17, 8'hA5});
    rd(4'd3, d); chk("R1", "index readback", d, 32'd17);
    settle();

    // R4 long reply
    ldat = 120'hF1E2D3C4B5A69788_796A5B4C3D2E1F;
    launch(4'd2, 6'd2, 32'h0, 2, '0, ldat, 3, 0, 0, 8'h00);
    wait_idle("R7");
    rd(4'd2, d); chk("R4", "no errors long", d, 32'h80);
    begin
      logic [135:0] lr;
      lr = {2'b00, 6'h3f, ldat, crc7f({8'h0, ldat}, 120), 1'b1};
      for (int k = 0; k < 4; k++) begin
        rd(4'(5 + k), d); chk("R4", $sformatf("rsp%0d", k), d, lr[32*k +: 32]);
      end
      rd(4'd9, d); chk("R4", "rsp4 header", d, 32'h3f);
    end
    settle();

    // R5 bad CRC
    launch(4'd1, 6'd13, 32'hCAFE_0001, 1, 32'h0000_0900, '0, 2, 1, 0, 8'h00);
    wait_idle("R7");
    rd(4'd2, d); chk("R5", "crc error flag", d, 32'h81);
    settle();

    // R6 window boundary: start at 64th sample accepted
    launch(4'd1, 6'd7, 32'h0000_0042, 1, 32'h1111_2222, '0, 63, 0, 0, 8'h00);
    wait_idle("R7");
    rd(4'd2, d); chk("R6", "reply at last sample accepted", d, 32'h80);
    settle();
    // R6 one cycle later is missed
    launch(4'd1, 6'd7, 32'h0000_0043, 1, 32'h1111_2222, '0, 64, 0, 0, 8'h00);
    wait_idle("R7");
    rd(4'd2, d); chk("R6", "late reply gives no response", d, 32'h90);
    settle();

    // R11 flags cleared on new launch; R13 writes ignored while busy
    launch(4'd1, 6'd55, 32'h0BAD_F00D, 1, 32'h7654_3210, '0, 10, 0, 0, 8'h00);
    rd(4'd2, d); chk("R11", "flags cleared at launch", d, 32'h80);
    wr(4'd4, 32'hDEAD_BEEF);
    wr(4'd3, 32'd9);
    wr(4'd1, 32'h0000_0004);
    rd(4'd1, d); chk("R13", "ctrl write ignored while busy", d, 32'h0000_0081);
    wait_idle("R7");
    rd(4'd4, d); chk("R13", "arg unchanged", d, 32'h0BAD_F00D);
    rd(4'd3, d); chk("R13", "index unchanged", d, 32'd55);
    rd(4'd6, d); chk("R3", "rsp1 second pattern", d, {16'h0, 2'b00, 6'd55, 8'h76});
    settle();

    // R9 R12 busy wait released by DAT0
    launch(4'd3, 6'd38, 32'h0000_0000, 1, 32'h0000_0800, '0, 1, 0, 300, 8'h5A);
    while (dat0) @(negedge clk);
    repeat (20) @(negedge clk);
    rd(4'd1, d); chk("R9", "launch held while busy", {31'h0, d[7]}, 32'h1);
    rd(4'd2, d); chk("R12", "state shows DAT0 low", d, 32'h00);
    wait_idle("R9");
    rd(4'd2, d); chk("R9", "busy released cleanly", d, 32'h80);
    rd(4'd1, d); chk("R8", "ctrl after busy", d, 32'h005A_0003);
    settle();

    // R9 busy expiry
    launch(4'd3, 6'd38, 32'h0000_0001, 1, 32'h0000_0800, '0, 1, 0, 1100, 8'h00);
    wait_idle("R9");
    rd(4'd2, d); chk("R9", "busy expiry gives no response", {27'h0, d[4:0]}, 32'h10);
    repeat (1100) @(negedge clk);

    // R10 unsupported codes
    for (int m = 4; m <= 5; m++) begin
      fs = frames_seen;
      launch(4'(m), 6'd18, 32'h0000_0200, 0, '0, '0, 0, 0, 0, 8'h00);
      wait_idle("R10");
      rd(4'd2, d); chk("R10", "unsupported sets no response", d, 32'h90);
      repeat (60) @(negedge clk);
      chk("R10", "no frame sent", frames_seen, fs);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule